// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler and bit destuffer. It takes the stream of frame bits with stuff bits already removed. Each bit arrives with a strobe and its index within the frame, where index 0 is the start-of-frame bit. From this stream it recovers the fields of data and remote frames, in both the 11-bit-identifier layout and the 29-bit-identifier layout. The layout is chosen by the identifier-extension bit, and the position of every trailing field moves with the data length code.

When the last end-of-frame bit has been taken, all captured fields are presented together on a set of held output registers, and a one-cycle completion strobe is raised. The outputs are the identifier, the format, the remote flag, the length code, the payload, the 15-bit CRC field and the acknowledge status. Protocol violations are reported on a live warning vector. Two status lines go back to the sampler. One tells it to stop removing stuff bits, because the fixed-form trailer has been reached. The other tells it when the bus may be treated as free again, which is after the intermission. The block does not compute the CRC, does not handle error or overload frames, and does not transmit.

Top module: `can_field_parser`

## Requirements
- R1: During and right after reset, every captured field output, frame_done, stop_stuff and all warn bits are 0, and bus_free is 1.
- R2: In a frame whose bit 13 is 0 (dominant), the parser takes the following fields. The identifier is bits 1..11, MSB first, and appears on frame_id[10:0] with the upper bits 0. The remote flag is bit 12. The length code is bits 15..18, MSB first. frame_ext is 0.
- R3: In a frame whose bit 13 is 1 (recessive), bits 14..31 form the low 18 identifier bits, MSB first. frame_id is {bits 1..11, bits 14..31}. The remote flag is bit 32, the length code is bits 35..38, and frame_ext is 1.
- R4: The payload starts right after the last length-code bit and holds min(DLC,8) bytes, or no bytes when the remote flag is 1. Each byte arrives MSB first. Byte i appears on frame_data[8i+7:8i], and bytes that were not received read 0.
- R5: The 15 bits after the last payload bit are the CRC field, MSB first, and appear on frame_crc. frame_ack is 1 when the bit at last payload index + 17 is dominant (0).
- R6: frame_done is high for exactly one cycle, in the cycle after the bit at last payload index + 25 is accepted. The captured field outputs change only in that cycle.
- R7: stop_stuff rises in the cycle after the last CRC bit (last payload index + 15) is accepted. It stays high until a bit with index 0 is accepted.
- R8: The warn bits are: [0] bit 0 recessive, [1] identifier bits ID[10:4] all recessive, [2] CRC delimiter (+16) dominant, [3] ACK delimiter (+18) dominant, [4] any end-of-frame bit (+19..+25) dominant. Each bit stays set until the next index-0 bit is accepted, and that bit reloads bit [0] and clears the rest.
- R9: The reserved bits and the substitute-remote bit of extended frames have no effect on any output.
- R10: bus_free clears when an index-0 bit is accepted. It sets in the cycle after the bit at last payload index + 28 is accepted, provided the three intermission bits (+26..+28) were all recessive.
- R11: A cycle with bit_valid low changes no output and no captured state, whatever bit_val and bit_idx hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe: a destuffed frame bit is presented |
| bit_val | input | 1 | Bit level, 0 dominant, 1 recessive |
| bit_idx | input | IDX_W | Index of the bit within the frame, 0 at start of frame |
| frame_id | output | 29 | Captured identifier |
| frame_ext | output | 1 | Captured format, 1 for extended |
| frame_rtr | output | 1 | Captured remote flag |
| frame_dlc | output | 4 | Captured raw length code |
| frame_data | output | 8*MAX_BYTES | Captured payload, byte i at [8i+7:8i] |
| frame_crc | output | 15 | Captured CRC field |
| frame_ack | output | 1 | 1 when the acknowledge slot was dominant |
| frame_done | output | 1 | One-cycle completion strobe |
| stop_stuff | output | 1 | Tells the sampler to stop destuffing |
| bus_free | output | 1 | Intermission over, bus is idle |
| warn | output | 5 | Live protocol warning flags |

## Verification
The bench drives six frames, each chosen to separate one layout decision from another. A standard data frame with a recessive reserved bit is set against an eight-byte extended frame with a recessive substitute bit. A standard remote frame carries a non-zero length code, which shows that payload capture is gated by the remote flag. A standard frame with a length code of 12 shows the cap at eight bytes. An extended remote frame with length 0 places the trailer directly after the length code. One frame carries every violation at once: recessive start bit, a forbidden identifier, dominant delimiters, one dominant end-of-frame bit and a dominant intermission bit. It is followed by a clean frame, which shows that the warnings clear and that bus_free is withheld only for the faulty frame. Idle cycles with misleading bit_val and bit_idx values are placed throughout every frame.

// File: rtl/can_fp_pkg.sv
// Package: shared field positions and widths for the CAN frame field parser.
// Positions are frame-bit indices after destuffing; trailer positions are
// offsets from the last payload bit index.
package can_fp_pkg;

    localparam int unsigned BASE_W = 11;
    localparam int unsigned EXT_W  = 18;
    localparam int unsigned ID_W   = BASE_W + EXT_W;
    localparam int unsigned DLC_W  = 4;
    localparam int unsigned CRC_W  = 15;
    localparam int unsigned WARN_W = 5;
    localparam int unsigned ID_CHK_N = 7;

    // header positions
    localparam int unsigned POS_SOF       = 0;
    localparam int unsigned POS_ID_FIRST  = 1;
    localparam int unsigned POS_ID_LAST   = 11;
    localparam int unsigned POS_RTR_SRR   = 12;
    localparam int unsigned POS_IDE       = 13;
    localparam int unsigned STD_DLC_FIRST = 15;
    localparam int unsigned STD_DLC_LAST  = 18;
    localparam int unsigned EXT_ID_FIRST  = 14;
    localparam int unsigned EXT_ID_LAST   = 31;
    localparam int unsigned EXT_RTR       = 32;
    localparam int unsigned EXT_DLC_FIRST = 35;
    localparam int unsigned EXT_DLC_LAST  = 38;

    // trailer offsets relative to the last payload bit
    localparam int unsigned REL_CRC_FIRST = 1;
    localparam int unsigned REL_CRC_LAST  = 15;
    localparam int unsigned REL_CRC_DELIM = 16;
    localparam int unsigned REL_ACK       = 17;
    localparam int unsigned REL_ACK_DELIM = 18;
    localparam int unsigned REL_EOF_FIRST = 19;
    localparam int unsigned REL_EOF_LAST  = 25;
    localparam int unsigned REL_IFS_LAST  = 28;

    // warning vector bit positions
    localparam int unsigned W_SOF  = 0;
    localparam int unsigned W_ID   = 1;
    localparam int unsigned W_CRCD = 2;
    localparam int unsigned W_ACKD = 3;
    localparam int unsigned W_EOF  = 4;

    typedef logic [ID_W-1:0]   can_id_t;
    typedef logic [WARN_W-1:0] can_warn_t;

endpackage

// File: rtl/can_fp_header.sv
// Module: can_fp_header
// Captures the header of a frame: base identifier, extension identifier,
// format bit, remote flag and length code. It also flags a recessive start
// bit and a forbidden identifier pattern.
// Assumes: bits arrive destuffed, in order, with index 0 starting each frame.
module can_fp_header
    import can_fp_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_valid,
    input  logic                bit_val,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic [BASE_W-1:0]   base_id,
    output logic [EXT_W-1:0]    ext_id,
    output logic                ide,
    output logic                rtr,
    output logic [DLC_W-1:0]    dlc,
    output logic                warn_sof,
    output logic                warn_id
);

    localparam int unsigned ID_CHK_HI = BASE_W - 2;
    localparam int unsigned ID_CHK_LO = ID_CHK_HI - ID_CHK_N + 1;

    int unsigned idx;
    logic        bit12;

    // widen the index once for all position compares
    always_comb idx = 32'(bit_idx);

    // shift header fields in as their positions come by
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_id  <= '0;
            ext_id   <= '0;
            ide      <= 1'b0;
            rtr      <= 1'b0;
            dlc      <= '0;
            bit12    <= 1'b0;
            warn_sof <= 1'b0;
            warn_id  <= 1'b0;
        end else if (bit_valid) begin
            if (idx == POS_SOF) begin
                base_id  <= '0;
                ext_id   <= '0;
                ide      <= 1'b0;
                rtr      <= 1'b0;
                dlc      <= '0;
                bit12    <= 1'b0;
                warn_sof <= bit_val;
                warn_id  <= 1'b0;
            end else if (idx >= POS_ID_FIRST && idx <= POS_ID_LAST) begin
                base_id <= {base_id[BASE_W-2:0], bit_val};
                if (idx == POS_ID_LAST)
                    warn_id <= &base_id[ID_CHK_HI:ID_CHK_LO];
            end else if (idx == POS_RTR_SRR) begin
                bit12 <= bit_val;
            end else if (idx == POS_IDE) begin
                ide <= bit_val;
                rtr <= bit_val ? 1'b0 : bit12;
            end else if (!ide) begin
                if (idx >= STD_DLC_FIRST && idx <= STD_DLC_LAST)
                    dlc <= {dlc[DLC_W-2:0], bit_val};
            end else begin
                if (idx >= EXT_ID_FIRST && idx <= EXT_ID_LAST)
                    ext_id <= {ext_id[EXT_W-2:0], bit_val};
                else if (idx == EXT_RTR)
                    rtr <= bit_val;
                else if (idx >= EXT_DLC_FIRST && idx <= EXT_DLC_LAST)
                    dlc <= {dlc[DLC_W-2:0], bit_val};
            end
        end
    end

    // R11: an idle cycle leaves the header untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable({base_id, ext_id, ide, rtr, dlc, warn_sof, warn_id}));

endmodule

// File: rtl/can_fp_layout.sv
// Module: can_fp_layout
// Works out, from the captured header, where the payload ends. It then
// classifies the current index as payload (with its bit offset) or
// trailer (with its offset from the last payload bit).
// Assumes: the header fields are complete before the first payload index.
module can_fp_layout
    import can_fp_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned MAX_BYTES = 8,
    parameter int unsigned OFF_W     = 6,
    parameter int unsigned REL_W     = 5
) (
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              ide,
    input  logic              rtr,
    input  logic [DLC_W-1:0]  dlc,
    output logic              in_data,
    output logic [OFF_W-1:0]  data_off,
    output logic              in_tail,
    output logic [REL_W-1:0]  tail_rel
);

    int unsigned idx;
    int unsigned dlc_end;
    int unsigned dlc_u;
    int unsigned n_bytes;
    int unsigned last_data;

    // locate payload end and classify the current index
    always_comb begin
        idx       = 32'(bit_idx);
        dlc_u     = 32'(dlc);
        dlc_end   = ide ? EXT_DLC_LAST : STD_DLC_LAST;
        if (rtr)
            n_bytes = 0;
        else if (dlc_u > MAX_BYTES)
            n_bytes = MAX_BYTES;
        else
            n_bytes = dlc_u;
        last_data = dlc_end + 8 * n_bytes;
        in_data   = (idx > dlc_end) && (idx <= last_data);
        data_off  = OFF_W'(idx - dlc_end - 1);
        in_tail   = (idx > last_data) && (idx <= last_data + REL_IFS_LAST);
        tail_rel  = REL_W'(idx - last_data);
    end

endmodule

// File: rtl/can_fp_payload.sv
// Module: can_fp_payload
// Stores the payload bits at their byte/bit slots, shifts in the CRC field
// and records the acknowledge slot.
// Assumes: in_data/data_off and in_tail/tail_rel come from can_fp_layout.
module can_fp_payload
    import can_fp_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 8,
    parameter int unsigned OFF_W     = 6,
    parameter int unsigned REL_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid,
    input  logic                    bit_val,
    input  logic                    sof_slot,
    input  logic                    in_data,
    input  logic [OFF_W-1:0]        data_off,
    input  logic                    in_tail,
    input  logic [REL_W-1:0]        tail_rel,
    output logic [8*MAX_BYTES-1:0]  data,
    output logic [CRC_W-1:0]        crc,
    output logic                    ack
);

    int unsigned rel;
    logic [OFF_W-1:0] slot;

    // map a payload offset to its slot: byte-major, MSB first in a byte
    always_comb begin
        rel  = 32'(tail_rel);
        slot = {data_off[OFF_W-1:3], ~data_off[2:0]};
    end

    // capture payload, CRC and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            crc  <= '0;
            ack  <= 1'b0;
        end else if (bit_valid) begin
            if (sof_slot) begin
                data <= '0;
                crc  <= '0;
                ack  <= 1'b0;
            end else if (in_data) begin
                data[slot] <= bit_val;
            end else if (in_tail) begin
                if (rel >= REL_CRC_FIRST && rel <= REL_CRC_LAST)
                    crc <= {crc[CRC_W-2:0], bit_val};
                else if (rel == REL_ACK)
                    ack <= ~bit_val;
            end
        end
    end

    // R11: nothing moves without a strobe
    p_payload_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable({data, crc, ack}));

endmodule

// File: rtl/can_fp_trailer.sv
// Module: can_fp_trailer
// Tracks the fixed trailer. It raises stop_stuff after the CRC field,
// flags dominant delimiter and end-of-frame bits, produces the completion
// strobe and decides when the bus is free after the intermission.
// Assumes: tail_rel is valid whenever in_tail is high.
module can_fp_trailer
    import can_fp_pkg::*;
#(
    parameter int unsigned REL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              sof_slot,
    input  logic              in_tail,
    input  logic [REL_W-1:0]  tail_rel,
    output logic              last_eof,
    output logic              done,
    output logic              stop_stuff,
    output logic              bus_free,
    output logic              warn_crcd,
    output logic              warn_ackd,
    output logic              warn_eof
);

    int unsigned rel;
    logic        ifs_ok;

    // detect the final end-of-frame bit being accepted
    always_comb begin
        rel      = 32'(tail_rel);
        last_eof = bit_valid && in_tail && (rel == REL_EOF_LAST);
    end

    // trailer state: stuffing stop, warnings, intermission, strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            stop_stuff <= 1'b0;
            bus_free   <= 1'b1;
            warn_crcd  <= 1'b0;
            warn_ackd  <= 1'b0;
            warn_eof   <= 1'b0;
            ifs_ok     <= 1'b0;
        end else begin
            done <= last_eof;
            if (bit_valid) begin
                if (sof_slot) begin
                    stop_stuff <= 1'b0;
                    bus_free   <= 1'b0;
                    warn_crcd  <= 1'b0;
                    warn_ackd  <= 1'b0;
                    warn_eof   <= 1'b0;
                    ifs_ok     <= 1'b0;
                end else if (in_tail) begin
                    if (rel == REL_CRC_LAST)
                        stop_stuff <= 1'b1;
                    if (rel == REL_CRC_DELIM)
                        warn_crcd <= warn_crcd | ~bit_val;
                    if (rel == REL_ACK_DELIM)
                        warn_ackd <= warn_ackd | ~bit_val;
                    if (rel >= REL_EOF_FIRST && rel <= REL_EOF_LAST)
                        warn_eof <= warn_eof | ~bit_val;
                    if (rel == REL_EOF_LAST)
                        ifs_ok <= 1'b1;
                    else if (rel > REL_EOF_LAST && rel < REL_IFS_LAST)
                        ifs_ok <= ifs_ok & bit_val;
                    else if (rel == REL_IFS_LAST)
                        bus_free <= ifs_ok & bit_val;
                end
            end
        end
    end

    // R6: the completion strobe lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a finished frame is always past the CRC field
    p_done_in_trailer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stop_stuff);

    // R10: a start bit ends both the free state and the stuffing stop
    p_sof_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && sof_slot) |=> (!bus_free && !stop_stuff));

endmodule

// File: rtl/can_field_parser.sv
// Module: can_field_parser (top)
// Decodes destuffed CAN data and remote frames, standard and extended.
// It presents the captured fields on held registers together with a
// completion strobe.
// Assumes: one bit per bit_valid strobe, indices counting up from 0.
module can_field_parser
    import can_fp_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned MAX_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid,
    input  logic                    bit_val,
    input  logic [IDX_W-1:0]        bit_idx,
    output logic [ID_W-1:0]         frame_id,
    output logic                    frame_ext,
    output logic                    frame_rtr,
    output logic [DLC_W-1:0]        frame_dlc,
    output logic [8*MAX_BYTES-1:0]  frame_data,
    output logic [CRC_W-1:0]        frame_crc,
    output logic                    frame_ack,
    output logic                    frame_done,
    output logic                    stop_stuff,
    output logic                    bus_free,
    output logic [WARN_W-1:0]       warn
);

    localparam int unsigned DATA_W = 8 * MAX_BYTES;
    localparam int unsigned OFF_W  = $clog2(DATA_W);
    localparam int unsigned REL_W  = $clog2(REL_IFS_LAST + 1);

    logic [BASE_W-1:0] base_id;
    logic [EXT_W-1:0]  ext_id;
    logic              ide, rtr;
    logic [DLC_W-1:0]  dlc;
    logic              warn_sof, warn_id;
    logic              in_data, in_tail;
    logic [OFF_W-1:0]  data_off;
    logic [REL_W-1:0]  tail_rel;
    logic [DATA_W-1:0] data;
    logic [CRC_W-1:0]  crc;
    logic              ack;
    logic              last_eof;
    logic              warn_crcd, warn_ackd, warn_eof;
    logic              sof_slot;

    // start-of-frame position decode shared by the submodules
    always_comb sof_slot = (bit_idx == '0);

    can_fp_header #(.IDX_W(IDX_W)) u_header (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .bit_idx(bit_idx), .base_id(base_id), .ext_id(ext_id), .ide(ide),
        .rtr(rtr), .dlc(dlc), .warn_sof(warn_sof), .warn_id(warn_id)
    );

    can_fp_layout #(
        .IDX_W(IDX_W), .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W), .REL_W(REL_W)
    ) u_layout (
        .bit_idx(bit_idx), .ide(ide), .rtr(rtr), .dlc(dlc),
        .in_data(in_data), .data_off(data_off),
        .in_tail(in_tail), .tail_rel(tail_rel)
    );

    can_fp_payload #(
        .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W), .REL_W(REL_W)
    ) u_payload (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .sof_slot(sof_slot), .in_data(in_data), .data_off(data_off),
        .in_tail(in_tail), .tail_rel(tail_rel),
        .data(data), .crc(crc), .ack(ack)
    );

    can_fp_trailer #(.REL_W(REL_W)) u_trailer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .sof_slot(sof_slot), .in_tail(in_tail), .tail_rel(tail_rel),
        .last_eof(last_eof), .done(frame_done), .stop_stuff(stop_stuff),
        .bus_free(bus_free), .warn_crcd(warn_crcd), .warn_ackd(warn_ackd),
        .warn_eof(warn_eof)
    );

    // gather the live warnings into their fixed positions
    always_comb begin
        warn         = '0;
        warn[W_SOF]  = warn_sof;
        warn[W_ID]   = warn_id;
        warn[W_CRCD] = warn_crcd;
        warn[W_ACKD] = warn_ackd;
        warn[W_EOF]  = warn_eof;
    end

    // publish the captured fields when the final end-of-frame bit lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_id   <= '0;
            frame_ext  <= 1'b0;
            frame_rtr  <= 1'b0;
            frame_dlc  <= '0;
            frame_data <= '0;
            frame_crc  <= '0;
            frame_ack  <= 1'b0;
        end else if (last_eof) begin
            frame_id   <= ide ? {base_id, ext_id} : {{EXT_W{1'b0}}, base_id};
            frame_ext  <= ide;
            frame_rtr  <= rtr;
            frame_dlc  <= dlc;
            frame_data <= data;
            frame_crc  <= crc;
            frame_ack  <= ack;
        end
    end

    // R6: the published fields move only alongside the strobe
    p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable({frame_id, frame_ext, frame_rtr, frame_dlc,
                                 frame_data, frame_crc, frame_ack}));

    // R8: a dominant start bit leaves no warning standing
    p_warn_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && sof_slot && !bit_val) |=> (warn == '0));

endmodule

// File: tb/sim_can_field_parser.sv
// Bench for can_field_parser. A behavioural model builds each frame as a
// bit queue, predicts every output after each clock and compares all of
// them on every falling edge.
module sim_can_field_parser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_valid;
    logic        bit_val;
    logic [7:0]  bit_idx;
    logic [28:0] frame_id;
    logic        frame_ext, frame_rtr;
    logic [3:0]  frame_dlc;
    logic [63:0] frame_data;
    logic [14:0] frame_crc;
    logic        frame_ack, frame_done, stop_stuff, bus_free;
    logic [4:0]  warn;

    always #10 clk = ~clk;

    can_field_parser u0 (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .bit_idx(bit_idx), .frame_id(frame_id), .frame_ext(frame_ext),
        .frame_rtr(frame_rtr), .frame_dlc(frame_dlc), .frame_data(frame_data),
        .frame_crc(frame_crc), .frame_ack(frame_ack), .frame_done(frame_done),
        .stop_stuff(stop_stuff), .bus_free(bus_free), .warn(warn)
    );

    int vectors = 0;
    int errors  = 0;
    string phase_tag = "";
    string id_tag = "R2";

    logic [28:0] e_id = '0;
    logic        e_ext = 0, e_rtr = 0, e_ack = 0, e_done = 0, e_stop = 0, e_free = 1;
    logic [3:0]  e_dlc = '0;
    logic [63:0] e_data = '0;
    logic [14:0] e_crc = '0;
    logic [4:0]  e_warn = '0;

    task automatic cmp(string tag, string name, logic [63:0] act, logic [63:0] exp);
        string t;
        t = (phase_tag != "") ? phase_tag : tag;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, name, act, exp);
        end
    endtask

    task automatic check_all();
        vectors++;
        cmp(id_tag, "frame_id",  64'(frame_id),  64'(e_id));
        cmp(id_tag, "frame_ext", 64'(frame_ext), 64'(e_ext));
        cmp(id_tag, "frame_rtr", 64'(frame_rtr), 64'(e_rtr));
        cmp(id_tag, "frame_dlc", 64'(frame_dlc), 64'(e_dlc));
        cmp("R4", "frame_data", frame_data, e_data);
        cmp("R5", "frame_crc",  64'(frame_crc), 64'(e_crc));
        cmp("R5", "frame_ack",  64'(frame_ack), 64'(e_ack));
        cmp("R6", "frame_done", 64'(frame_done), 64'(e_done));
        cmp("R7", "stop_stuff", 64'(stop_stuff), 64'(e_stop));
        cmp("R10", "bus_free",  64'(bus_free), 64'(e_free));
        cmp("R8", "warn",       64'(warn), 64'(e_warn));
    endtask

    // compare the state left by the previous edge, then drive the next input
    task automatic step(bit v, bit b, int idx);
        @(negedge clk);
        check_all();
        bit_valid = v;
        bit_val   = b;
        bit_idx   = idx[7:0];
        e_done    = 1'b0;
    endtask

    // build one frame and play it bit by bit, with R11 idle cycles between
    task automatic send_frame(bit ext, logic [28:0] id, bit rtr, logic [3:0] dlc,
                              logic [63:0] bytes, logic [14:0] crc, bit ack,
                              bit bad_sof, bit bad_crcd, bit bad_ackd,
                              int bad_eof, bit bad_ifs);
        int fb[$];
        logic [10:0] base;
        int neff, last;
        logic [63:0] xd;
        fb.delete();
        base = ext ? id[28:18] : id[10:0];
        fb.push_back(bad_sof ? 1 : 0);
        for (int k = 10; k >= 0; k--) fb.push_back(int'(base[k]));
        fb.push_back(ext ? 1 : int'(rtr));          // R9: substitute bit recessive
        fb.push_back(int'(ext));
        if (!ext) begin
            fb.push_back(1);                        // R9: reserved bit recessive
        end else begin
            for (int k = 17; k >= 0; k--) fb.push_back(int'(id[k]));
            fb.push_back(int'(rtr));
            fb.push_back(1);                        // R9: reserved bits recessive
            fb.push_back(1);
        end
        for (int k = 3; k >= 0; k--) fb.push_back(int'(dlc[k]));
        neff = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
        xd = '0;
        for (int i = 0; i < neff; i++) begin
            for (int k = 7; k >= 0; k--) fb.push_back(int'(bytes[8*i+k]));
            xd[8*i +: 8] = bytes[8*i +: 8];
        end
        last = fb.size() - 1;
        for (int k = 14; k >= 0; k--) fb.push_back(int'(crc[k]));
        fb.push_back(bad_crcd ? 0 : 1);
        fb.push_back(ack ? 0 : 1);
        fb.push_back(bad_ackd ? 0 : 1);
        for (int k = 0; k < 7; k++) fb.push_back((bad_eof == k) ? 0 : 1);
        for (int k = 0; k < 3; k++) fb.push_back((bad_ifs && k == 1) ? 0 : 1);

        for (int i = 0; i < fb.size(); i++) begin
            if (i % 4 == 1) step(0, i[0], 0);       // R11: strobe low, index 0
            step(1, fb[i][0], i);
            if (i == 0) begin
                e_warn = {4'b0, fb[0][0]};
                e_free = 1'b0;
                e_stop = 1'b0;
            end
            if (i == 11 && base[10:4] == 7'h7f) e_warn[1] = 1'b1;
            if (i == last + 15) e_stop = 1'b1;
            if (i == last + 16 && fb[i] == 0) e_warn[2] = 1'b1;
            if (i == last + 18 && fb[i] == 0) e_warn[3] = 1'b1;
            if (i >= last + 19 && i <= last + 25 && fb[i] == 0) e_warn[4] = 1'b1;
            if (i == last + 25) begin
                e_done = 1'b1;
                id_tag = ext ? "R3" : "R2";
                e_id   = ext ? id : {18'b0, id[10:0]};
                e_ext  = ext;
                e_rtr  = rtr;
                e_dlc  = dlc;
                e_data = xd;
                e_crc  = crc;
                e_ack  = ack;
            end
            if (i == last + 28)
                e_free = (fb[last+26] == 1) && (fb[last+27] == 1) && (fb[last+28] == 1);
        end
        step(0, 1, 5);
        step(0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bit_valid = 1'b0;
        bit_val = 1'b0;
        bit_idx = '0;
        repeat (3) @(negedge clk);
        phase_tag = "R1";                            // R1: reset state
        check_all();
        rst_n = 1'b1;
        step(0, 0, 0);
        phase_tag = "";

        // R2 standard data frame, two bytes
        send_frame(0, 29'h123, 0, 4'd2, 64'h3CA5, 15'h5A5A, 1, 0, 0, 0, -1, 0);
        // R3 extended data frame, eight bytes, NACK
        send_frame(1, 29'h0ABCDEF1, 0, 4'd8, 64'h0123456789ABCDEF, 15'h1234, 0,
                   0, 0, 0, -1, 0);
        // R4 standard remote frame: length code ignored for payload
        send_frame(0, 29'h2AA, 1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 15'h7FFF, 1,
                   0, 0, 0, -1, 0);
        // R4 length code above eight is capped
        send_frame(0, 29'h001, 0, 4'd12, 64'h8877665544332211, 15'h0001, 1,
                   0, 0, 0, -1, 0);
        // R8 every violation, R10 dominant intermission bit keeps bus busy
        send_frame(0, 29'h7F0, 0, 4'd1, 64'h81, 15'h4000, 0, 1, 1, 1, 3, 1);
        // R3 extended remote frame with empty payload; warnings clear again
        send_frame(1, 29'h15555555, 1, 4'd0, 64'h0, 15'h2AAA, 1, 0, 0, 0, -1, 0);

        repeat (4) step(0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule